// File: doc/BRIEF.md
# Square-Wave Edge Frequency Meter

This block watches a one-bit speaker line that software toggles to make tones. It treats every change of the line, up or down, as an edge. It counts the clock cycles between two edges, which is one half-period of the square wave. A serial restoring divider then turns that count into a frequency in hertz. The result is half the configured clock rate divided by the count, because one full period holds two edges.

The clock-rate input tells the block how fast the sampling clock runs. The intended values are 4,000,000 and 400,000, but any value that fits the width is accepted. A rate that changes takes effect at the next division that starts.

If the line stays still for a fixed silence window after an edge, the block goes silent. It reports zero frequency and forgets its stored timestamp. The next edge after that only restarts the timing.

Top module: `edge_freq_meter`

## Requirements
- R1: While reset is asserted and after it is released, before any result: `silent` is 1 and `freq`, `half_period` and `valid` are 0.
- R2: A falling change of `spk_in` counts as an edge in the same way as a rising one. The line is compared with its value in the previous cycle, which is 0 after reset. A 1 at reset release is therefore an edge.
- R3: The first edge after reset produces no result and only records its cycle, and so does the first edge after the block went silent.
- R4: The cycle count between an edge that starts a division and the edge before it (the delta) appears on `half_period` together with `valid`.
- R5: `freq` is floor((`clk_rate` >> 1) / delta). It and `valid` update RATE_W clock edges after the edge that started the division, and `freq` holds its value at all other times except on silence.
- R6: An edge that arrives while a division is running starts no new division. It still replaces the stored timestamp, so the next delta is measured from it.
- R7: When SILENCE_CYC cycles have passed since the last recorded edge, `silent` goes to 1 and `freq` to 0 on the next cycle, and the stored timestamp is discarded. An edge in that very cycle is only recorded, as in R3.
- R8: A new result clears `silent`; `silent` and `valid` are never high together.
- R9: `valid` is a one-cycle pulse.
- R10: The cycle counter saturates instead of wrapping, and a delta of 0 never starts a division. Every reported `half_period` lies in 1 .. SILENCE_CYC-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spk_in | input | 1 | Speaker line toggled by software |
| clk_rate | input | RATE_W | Sampling clock rate in Hz |
| half_period | output | CNT_W | Cycles between the last two measured edges |
| freq | output | RATE_W | Measured frequency in Hz, 0 when silent |
| valid | output | 1 | One-cycle pulse when a new result is shown |
| silent | output | 1 | No edge within the silence window |

## Verification
The bench sends edges into a running division. A design that started a new division there, or failed to move the timestamp, would report the wrong half-period on the next result. It places edges exactly one cycle before and exactly on the end of the silence window: a meter off by one would report a 10000-cycle delta or miss the silent state, and one that ignored the coincident edge would drop the result that follows. It also checks the first edge after reset and after silence, a one-cycle delta that yields half the clock rate, and a switch of clock rate. An error in any of these shows up as a stray or missing `valid` pulse, or as a mismatch against the cycle-by-cycle model.

// File: rtl/sqfm_pkg.sv
package sqfm_pkg;

   typedef enum logic {
      DIV_IDLE = 1'b0,
      DIV_RUN  = 1'b1
   } div_state_e;

endpackage

// File: rtl/sqfm_sync.sv
// Optional input register chain; zero stages gives a plain wire.
module sqfm_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[i] <= 1'b0;
                  else        chain[i] <= d;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[i] <= 1'b0;
                  else        chain[i] <= chain[i-1];
               end
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sqfm_edge_timer.sv
// Edge detection, saturating gap counter, timestamp arming and silence window.
module sqfm_edge_timer #(
   parameter int CNT_W       = 16,
   parameter int SILENCE_CYC = 10000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spk,
   input  logic             div_busy,
   output logic             edge_seen,
   output logic             start,
   output logic             silence_hit,
   output logic [CNT_W-1:0] delta
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] SIL_L   = CNT_W'(SILENCE_CYC);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic             spk_q;
   logic             armed;
   logic [CNT_W-1:0] since;

   assign edge_seen   = spk ^ spk_q;
   assign silence_hit = armed && (since >= SIL_L);
   assign start       = edge_seen && armed && !silence_hit && !div_busy && (since != '0);
   assign delta       = since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spk_q <= 1'b0;
         since <= '0;
         armed <= 1'b0;
      end else begin
         spk_q <= spk;
         if (edge_seen)             since <= ONE;
         else if (since != CNT_MAX) since <= since + ONE;
         if (silence_hit)           armed <= edge_seen;
         else if (edge_seen)        armed <= 1'b1;
      end
   end

endmodule

// File: rtl/sqfm_divider.sv
// Restoring divider, one quotient bit per clock.
module sqfm_divider
   import sqfm_pkg::*;
#(
   parameter int NUM_W = 22,
   parameter int DEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             busy,
   output logic             done,
   output logic [NUM_W-1:0] quo_next,
   output logic [DEN_W-1:0] den_held
);

   localparam int STEP_W = $clog2(NUM_W + 1);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_W - 1);

   div_state_e       state;
   logic [DEN_W-1:0] rem;
   logic [DEN_W-1:0] rem_nx;
   logic [NUM_W-1:0] quo;
   logic [DEN_W-1:0] den_q;
   logic [STEP_W-1:0] step;
   logic [DEN_W:0]   trial;
   logic [DEN_W:0]   diff;
   logic             fits;

   always_comb begin
      trial    = {rem, quo[NUM_W-1]};
      fits     = trial >= {1'b0, den_q};
      diff     = trial - {1'b0, den_q};
      rem_nx   = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      quo_next = {quo[NUM_W-2:0], fits};
   end

   assign busy     = (state == DIV_RUN);
   assign done     = busy && (step == LAST_STEP);
   assign den_held = den_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= DIV_IDLE;
         rem   <= '0;
         quo   <= '0;
         den_q <= '0;
         step  <= '0;
      end else begin
         case (state)
            DIV_IDLE: begin
               if (start) begin
                  state <= DIV_RUN;
                  rem   <= '0;
                  quo   <= num;
                  den_q <= den;
                  step  <= '0;
               end
            end
            DIV_RUN: begin
               rem  <= rem_nx;
               quo  <= quo_next;
               step <= step + STEP_W'(1);
               if (done) state <= DIV_IDLE;
            end
            default: state <= DIV_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/edge_freq_meter.sv
module edge_freq_meter #(
   parameter int RATE_W      = 22,
   parameter int CNT_W       = 16,
   parameter int SILENCE_CYC = 10000,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spk_in,
   input  logic [RATE_W-1:0] clk_rate,
   output logic [CNT_W-1:0]  half_period,
   output logic [RATE_W-1:0] freq,
   output logic              valid,
   output logic              silent
);

   generate
      if (RATE_W < 2) begin : g_bad_rate
         $error("RATE_W must be at least 2");
      end
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt
         $error("CNT_W must be in 2..31");
      end
      if (SILENCE_CYC < 2 || SILENCE_CYC >= (1 << CNT_W)) begin : g_bad_sil
         $error("SILENCE_CYC must fit below the counter ceiling");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be in 0..4");
      end
   endgenerate

   logic              spk_s;
   logic              edge_seen;
   logic              start;
   logic              silence_hit;
   logic [CNT_W-1:0]  delta;
   logic              div_busy;
   logic              div_done;
   logic [RATE_W-1:0] quo_next;
   logic [CNT_W-1:0]  den_held;
   logic [RATE_W-1:0] half_rate;

   assign half_rate = clk_rate >> 1;

   sqfm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (spk_in),
      .q     (spk_s)
   );

   sqfm_edge_timer #(.CNT_W(CNT_W), .SILENCE_CYC(SILENCE_CYC)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .spk         (spk_s),
      .div_busy    (div_busy),
      .edge_seen   (edge_seen),
      .start       (start),
      .silence_hit (silence_hit),
      .delta       (delta)
   );

   sqfm_divider #(.NUM_W(RATE_W), .DEN_W(CNT_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .num      (half_rate),
      .den      (delta),
      .busy     (div_busy),
      .done     (div_done),
      .quo_next (quo_next),
      .den_held (den_held)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_period <= '0;
         freq        <= '0;
         valid       <= 1'b0;
         silent      <= 1'b1;
      end else begin
         valid <= div_done;
         if (div_done) begin
            freq        <= quo_next;
            half_period <= den_held;
            silent      <= 1'b0;
         end else if (silence_hit) begin
            freq   <= '0;
            silent <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/sqfm_checker.sv
module sqfm_checker #(
   parameter int RATE_W      = 22,
   parameter int CNT_W       = 16,
   parameter int SILENCE_CYC = 10000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              edge_seen,
   input logic              valid,
   input logic              silent,
   input logic [RATE_W-1:0] freq,
   input logic [CNT_W-1:0]  half_period
);

   localparam logic [CNT_W:0] GAP_MAX = '1;
   localparam logic [CNT_W:0] SIL_G   = (CNT_W+1)'(SILENCE_CYC);

   logic [CNT_W:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                gap <= '0;
      else if (edge_seen)        gap <= (CNT_W+1)'(1);
      else if (gap != GAP_MAX)   gap <= gap + (CNT_W+1)'(1);
   end

   assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   assert_period_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (half_period != '0) && (half_period < CNT_W'(SILENCE_CYC)));

   assert_silent_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> !silent);

   assert_silent_zero_freq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      silent |-> (freq == '0));

   assert_window_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (gap == SIL_G) |=> silent);

   assert_freq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(freq) |-> (valid || silent));

endmodule

bind edge_freq_meter sqfm_checker #(
   .RATE_W      (RATE_W),
   .CNT_W       (CNT_W),
   .SILENCE_CYC (SILENCE_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .edge_seen   (edge_seen),
   .valid       (valid),
   .silent      (silent),
   .freq        (freq),
   .half_period (half_period)
);

// File: tb/edge_freq_meter_test.sv
module edge_freq_meter_test;

   localparam int RATE_W = 22;
   localparam int CNT_W  = 16;
   localparam int SIL    = 10000;
   localparam int CMAX   = (1 << CNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              spk = 1'b0;
   logic [RATE_W-1:0] rate = RATE_W'(4000000);
   logic [CNT_W-1:0]  half_period;
   logic [RATE_W-1:0] freq;
   logic              valid;
   logic              silent;

   int checks = 0;
   int errors = 0;
   bit timeout = 1'b0;

   always #5 clk = ~clk;

   edge_freq_meter #(.RATE_W(RATE_W), .CNT_W(CNT_W), .SILENCE_CYC(SIL)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .spk_in      (spk),
      .clk_rate    (rate),
      .half_period (half_period),
      .freq        (freq),
      .valid       (valid),
      .silent      (silent)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference model, updated on each rising edge.
   int m_last, m_since, m_armed, m_left, m_pdelta, m_pfreq;
   int e_valid, e_freq, e_period, e_silent;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_last = 0; m_since = 0; m_armed = 0; m_left = 0;
         e_valid = 0; e_freq = 0; e_period = 0; e_silent = 1;
      end else begin
         int  edge_now;
         int  busy_was;
         int  sil_now;
         edge_now = (int'(spk) != m_last);
         busy_was = (m_left > 0);
         sil_now  = (m_armed != 0) && (m_since >= SIL);
         e_valid  = 0;
         if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
               e_valid = 1; e_freq = m_pfreq; e_period = m_pdelta; e_silent = 0;
            end
         end
         if (sil_now) begin
            e_silent = 1; e_freq = 0;
         end
         if (edge_now != 0) begin
            if (m_armed != 0 && sil_now == 0 && busy_was == 0 && m_since > 0) begin
               m_left   = RATE_W;
               m_pdelta = m_since;
               m_pfreq  = (int'(rate) / 2) / m_since;
            end
            m_since = 1;
            m_armed = 1;
         end else begin
            if (sil_now) m_armed = 0;
            if (m_since < CMAX) m_since++;
         end
         m_last = int'(spk);
      end
   end

   int vcount = 0;
   int last_per = 0;
   int last_freq = 0;

   always @(negedge clk) begin
      if (rst_n && !timeout) begin
         chk("R9 valid", valid, e_valid);
         chk("R5 freq", freq, e_freq);
         chk("R4 half_period", half_period, e_period);
         chk("R7 silent", silent, e_silent);
         if (valid) begin
            vcount++;
            last_per  = int'(half_period);
            last_freq = int'(freq);
            chk("R10 period nonzero", (half_period != 0), 1);
         end
      end
   end

   task automatic flip(input int n);
      repeat (n) @(negedge clk);
      spk = ~spk;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      timeout = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int base;
      idle(4);
      chk("R1 silent at reset", silent, 1);
      chk("R1 freq at reset", freq, 0);
      chk("R1 period at reset", half_period, 0);
      chk("R1 valid at reset", valid, 0);
      rst_n = 1'b1;
      idle(2);
      chk("R1 silent after release", silent, 1);

      // first edge only records a timestamp
      flip(3);
      idle(40);
      chk("R3 no result after first edge", vcount, 0);

      // falling edge, delta 100
      flip(60);
      idle(30);
      chk("R2 falling edge result count", vcount, 1);
      chk("R4 delta 100", last_per, 100);
      chk("R5 freq for delta 100", last_freq, 20000);

      // rising edge, delta 60
      flip(30);
      idle(30);
      chk("R2 rising edge result count", vcount, 2);
      chk("R5 freq for delta 60", last_freq, 33333);

      // edge during a running division
      flip(50);
      flip(5);
      flip(50);
      idle(30);
      chk("R6 busy edge gives no result", vcount, 4);
      chk("R6 delta from busy-edge timestamp", last_per, 50);
      chk("R6 freq for delta 50", last_freq, 40000);

      // slow clock rate
      rate = RATE_W'(400000);
      flip(10);
      idle(30);
      chk("R5 slow rate delta", last_per, 40);
      chk("R5 slow rate freq", last_freq, 5000);

      // silence window
      idle(SIL);
      chk("R7 silent after window", silent, 1);
      chk("R7 freq zero after window", freq, 0);
      base = vcount;
      flip(10);
      idle(30);
      chk("R3 first edge after silence", vcount, base);
      flip(10);
      idle(30);
      chk("R8 result clears silent", silent, 0);
      chk("R8 result after silence", vcount, base + 1);
      chk("R5 freq after silence", last_freq, 5000);

      // window boundaries
      rate = RATE_W'(4000000);
      flip(SIL - 1 - 30);
      idle(30);
      chk("R10 delta one below window", last_per, SIL - 1);
      chk("R5 freq one below window", last_freq, 200);
      base = vcount;
      flip(SIL - 30);
      idle(30);
      chk("R7 edge on expiry cycle goes silent", silent, 1);
      chk("R7 edge on expiry cycle gives no result", vcount, base);
      flip(5);
      idle(30);
      chk("R7 expiry edge kept as timestamp", vcount, base + 1);
      chk("R4 delta from expiry edge", last_per, 35);

      // one-cycle delta right after a division finishes
      flip(40);
      flip(22);
      flip(1);
      idle(30);
      chk("R10 minimum delta", last_per, 1);
      chk("R5 freq for delta 1", last_freq, 2000000);

      idle(5);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule